// File: doc/BRIEF.md
# Ping-Pong Burst Frame Controller

This block sequences one frame of a half-duplex two-wire digital loop on the line-card (master) side. A frame sync pulse latches the backplane voice byte and two signaling bits, then sends them as a 10-bit serial burst. Each burst bit is held for a fixed number of clock cycles, which sets the 256 kbit/s line rate. After its own burst ends, the block listens for the far end's 10-bit reply. The modem model delivers the reply one bit at a time, each bit with a strobe. The reply is unpacked into a received voice byte and two signaling bits. The link rate is one frame per 125 µs.

An LSB-data mode lets signaling bit 1 travel in the least significant bit of the backplane PCM byte, in both directions. A loopback mode keeps the line quiet and feeds the block's own burst straight into its receiver, for in-system testing. If no complete reply has arrived when the next frame sync comes, a missed-frame flag is set and the last received data stays on the outputs.

Top module: `ppb_frame_ctrl`

## Requirements
- R1: A burst carries 10 bits in this order: the voice byte MSB first, then the slot for signaling bit 1, then the slot for signaling bit 2.
- R2: A frame sync accepted at a clock edge raises `line_tx_en` from that edge on, for exactly 10×BIT_DIV cycles. Each burst bit holds on `line_tx` for BIT_DIV cycles.
- R3: Reply strobes on `line_rx_stb` are ignored while the block is idle or sending. Only strobes that arrive after its own burst has ended count toward the reply.
- R4: At the clock edge that samples the tenth accepted reply strobe, three things happen. `rx_pcm`, `rx_sig1` and `rx_sig2` take the reply's fields. `rx_valid` pulses high for one cycle. `frame_missed` clears.
- R5: With `lsb_data_en` high, the signaling-1 slot of the burst carries `tx_pcm[0]` and the value on `tx_sig1` is ignored. With `lsb_data_en` low, that slot carries `tx_sig1`.
- R6: With `lsb_data_en` high, `rx_pcm[0]` shows the received signaling-1 bit in place of the received voice LSB.
- R7: A frame sync that arrives while the block still waits for a reply sets `frame_missed`, leaves the receive outputs unchanged and starts a new burst.
- R8: A frame sync that arrives during a burst is ignored. The burst keeps its content and its length.
- R9: With `loopback_en` high, `line_tx_en` stays low and the line input is ignored. `rx_valid` rises 10×BIT_DIV cycles after the frame sync edge, with the block's own transmitted fields.
- R10: Reset clears `line_tx_en`, `line_tx`, `rx_pcm`, `rx_sig1`, `rx_sig2`, `rx_valid` and `frame_missed` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | One-cycle frame start pulse, once per 125 µs |
| tx_pcm | input | VOICE_W | Backplane voice byte to send |
| tx_sig1 | input | 1 | Signaling bit 1 to send |
| tx_sig2 | input | 1 | Signaling bit 2 to send |
| lsb_data_en | input | 1 | Carry signaling bit 1 in the PCM LSB |
| loopback_en | input | 1 | Route the own burst to the receiver, line quiet |
| line_tx | output | 1 | Serial burst bit to the modem |
| line_tx_en | output | 1 | Line-active strobe for the modem driver |
| line_rx | input | 1 | Received reply bit from the modem |
| line_rx_stb | input | 1 | One-cycle strobe marking a valid `line_rx` bit |
| rx_pcm | output | VOICE_W | Received voice byte |
| rx_sig1 | output | 1 | Received signaling bit 1 |
| rx_sig2 | output | 1 | Received signaling bit 2 |
| rx_valid | output | 1 | One-cycle pulse when a reply is complete |
| frame_missed | output | 1 | No reply arrived before the last frame sync |

## Verification
The burst is due on the cycle after the frame sync edge. The bench samples each bit at the first falling edge of its window, so samples fall BIT_DIV cycles apart. It then checks that the line-active strobe is still high in the 10×BIT_DIV-th cycle and low in the next one. Received fields are due at the edge that takes the tenth strobe, so the bench expects `rx_valid` at the falling edge just after that strobe. In loopback the bench counts falling edges from the frame sync and expects exactly 10×BIT_DIV of them. The missed-frame flag is checked at the first falling edge after the late frame sync.

// File: rtl/ppb_pkg.sv
// Shared types for the ping-pong burst frame controller.
package ppb_pkg;
    // Frame sequencer phases.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_WAIT  = 2'd2
    } ppb_state_e;

    // Signaling bits carried per burst in each direction.
    localparam int SIG_BITS = 2;
endpackage

// File: rtl/ppb_bit_timer.sv
// Bit timer: divides the clock into burst bit periods and counts the bits.
// Assumes BIT_DIV >= 2. start clears it; run lets it count.
module ppb_bit_timer #(
    parameter int BIT_DIV = 8,
    parameter int NBITS   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic tick,
    output logic last
);
    localparam int DIV_W = $clog2(BIT_DIV);
    localparam int CNT_W = $clog2(NBITS + 1);

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] bit_q;

    assign tick = run && (div_q == DIV_W'(BIT_DIV - 1));
    assign last = tick && (bit_q == CNT_W'(NBITS - 1));

    // Advance the cycle counter and, at each period end, the bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            div_q <= '0;
            bit_q <= '0;
        end else if (run) begin
            if (tick) begin
                div_q <= '0;
                bit_q <= last ? '0 : bit_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q < CNT_W'(NBITS)); // R1
endmodule

// File: rtl/ppb_burst_tx.sv
// Burst serializer: loads one frame word and shifts it out MSB first.
// Assumes load and shift are never high together.
module ppb_burst_tx #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    output logic              ser_bit
);
    logic [WORD_W-1:0] sreg_q;

    assign ser_bit = sreg_q[WORD_W-1];

    // Load at frame start and shift left once per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= load_word;
        end else if (shift) begin
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/ppb_burst_rx.sv
// Burst deserializer: collects strobed bits MSB first. done flags the last bit.
// word is valid in the cycle done is high and includes the bit on bit_in.
module ppb_burst_rx #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              stb,
    input  logic              bit_in,
    output logic              done,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-2:0] sreg_q;
    logic [CNT_W-1:0]  cnt_q;

    assign done = stb && (cnt_q == CNT_W'(WORD_W - 1));
    assign word = {sreg_q, bit_in};

    // Shift in each strobed bit and count toward a full word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (stb) begin
            sreg_q <= {sreg_q[WORD_W-3:0], bit_in};
            cnt_q  <= done ? '0 : cnt_q + 1'b1;
        end
    end

    AST_RX_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(WORD_W)); // R4
endmodule

// File: rtl/ppb_frame_ctrl.sv
// Master-side ping-pong frame controller. Each frame sync sends one burst
// (voice byte MSB first, sig1, sig2). It then waits for the far-end reply,
// which arrives as strobed bits. Assumes frame_sync is a one-cycle pulse
// and the modem model gives at most one strobe per cycle.
module ppb_frame_ctrl
    import ppb_pkg::*;
#(
    parameter int VOICE_W = 8,
    parameter int BIT_DIV = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_sync,
    input  logic [VOICE_W-1:0] tx_pcm,
    input  logic               tx_sig1,
    input  logic               tx_sig2,
    input  logic               lsb_data_en,
    input  logic               loopback_en,
    output logic               line_tx,
    output logic               line_tx_en,
    input  logic               line_rx,
    input  logic               line_rx_stb,
    output logic [VOICE_W-1:0] rx_pcm,
    output logic               rx_sig1,
    output logic               rx_sig2,
    output logic               rx_valid,
    output logic               frame_missed
);
    localparam int WORD_W = VOICE_W + SIG_BITS;

    ppb_state_e        state_q;
    logic              start;
    logic              bit_tick;
    logic              bit_last;
    logic              ser_bit;
    logic [WORD_W-1:0] tx_word;
    logic              rx_stb_int;
    logic              rx_bit_int;
    logic              rx_done;
    logic [WORD_W-1:0] rx_word;

    // A frame sync starts a burst unless one is already going out.
    assign start   = frame_sync && (state_q != ST_BURST);
    assign tx_word = {tx_pcm, (lsb_data_en ? tx_pcm[0] : tx_sig1), tx_sig2};

    // Receiver input: own burst in loopback, else line strobes while waiting.
    assign rx_stb_int = loopback_en ? bit_tick : ((state_q == ST_WAIT) && line_rx_stb);
    assign rx_bit_int = loopback_en ? ser_bit  : line_rx;

    assign line_tx_en = (state_q == ST_BURST) && !loopback_en;
    assign line_tx    = ser_bit && line_tx_en;

    ppb_bit_timer #(.BIT_DIV(BIT_DIV), .NBITS(WORD_W)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .run   (state_q == ST_BURST),
        .tick  (bit_tick),
        .last  (bit_last)
    );

    ppb_burst_tx #(.WORD_W(WORD_W)) ser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_word (tx_word),
        .shift     (bit_tick),
        .ser_bit   (ser_bit)
    );

    ppb_burst_rx #(.WORD_W(WORD_W)) des_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .stb    (rx_stb_int),
        .bit_in (rx_bit_int),
        .done   (rx_done),
        .word   (rx_word)
    );

    // Frame sequencer: idle -> burst -> wait for reply (or idle in loopback).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (start) state_q <= ST_BURST;
                ST_BURST: if (bit_last) state_q <= loopback_en ? ST_IDLE : ST_WAIT;
                ST_WAIT:  if (start) state_q <= ST_BURST;
                              else if (rx_done) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Receive outputs and the missed-frame flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_pcm       <= '0;
            rx_sig1      <= 1'b0;
            rx_sig2      <= 1'b0;
            rx_valid     <= 1'b0;
            frame_missed <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (start && (state_q == ST_WAIT)) begin
                frame_missed <= 1'b1;
            end else if (rx_done) begin
                rx_pcm       <= lsb_data_en ? {rx_word[WORD_W-1:3], rx_word[1]}
                                            : rx_word[WORD_W-1:2];
                rx_sig1      <= rx_word[1];
                rx_sig2      <= rx_word[0];
                rx_valid     <= 1'b1;
                frame_missed <= 1'b0;
            end
        end
    end

    AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
        line_tx_en |-> !rx_stb_int); // R3
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !bit_tick) |=> $stable(ser_bit)); // R2
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R4
    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_missed) |-> ($stable(rx_pcm) && $stable(rx_sig1) && $stable(rx_sig2))); // R7
    AST_BURST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !bit_last) |=> state_q == ST_BURST); // R8
endmodule

// File: tb/ppb_frame_ctrl_tb.sv
module ppb_frame_ctrl_tb_top;
    localparam int VW  = 8;
    localparam int DIV = 8;
    localparam int NB  = VW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_sync = 1'b0;
    logic [VW-1:0] tx_pcm = '0;
    logic tx_sig1 = 1'b0, tx_sig2 = 1'b0;
    logic lsb_data_en = 1'b0, loopback_en = 1'b0;
    logic line_tx, line_tx_en;
    logic line_rx = 1'b0, line_rx_stb = 1'b0;
    logic [VW-1:0] rx_pcm;
    logic rx_sig1, rx_sig2, rx_valid, frame_missed;

    int n_run = 0;
    int n_fail = 0;

    logic [NB-1:0] tx_q[$];
    logic [NB-1:0] rx_q[$];

    always #10 clk = ~clk; // 50 MHz

    ppb_frame_ctrl #(.VOICE_W(VW), .BIT_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .tx_pcm(tx_pcm), .tx_sig1(tx_sig1), .tx_sig2(tx_sig2),
        .lsb_data_en(lsb_data_en), .loopback_en(loopback_en),
        .line_tx(line_tx), .line_tx_en(line_tx_en),
        .line_rx(line_rx), .line_rx_stb(line_rx_stb),
        .rx_pcm(rx_pcm), .rx_sig1(rx_sig1), .rx_sig2(rx_sig2),
        .rx_valid(rx_valid), .frame_missed(frame_missed)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    // Driver: start a frame and queue the burst the line should carry.
    task automatic start_frame(input logic [VW-1:0] v, input logic s1, input logic s2);
        tx_pcm = v; tx_sig1 = s1; tx_sig2 = s2;
        frame_sync = 1'b1;
        if (!loopback_en) tx_q.push_back({v, (lsb_data_en ? v[0] : s1), s2});
        @(negedge clk);
        frame_sync = 1'b0;
    endtask

    task automatic wait_burst_end();
        while (!line_tx_en) @(negedge clk);
        while (line_tx_en) @(negedge clk);
    endtask

    // Driver: send a reply burst as strobed bits and queue the expected fields.
    task automatic send_reply(input logic [VW-1:0] v, input logic s1, input logic s2);
        logic [NB-1:0] w;
        w = {v, s1, s2};
        rx_q.push_back({(lsb_data_en ? {v[VW-1:1], s1} : v), s1, s2});
        for (int k = NB - 1; k >= 0; k--) begin
            line_rx = w[k]; line_rx_stb = 1'b1;
            @(negedge clk);
            line_rx_stb = 1'b0;
            if (k == 0) chk(rx_valid == 1'b1, "R4 rx_valid one edge after tenth strobe", rx_valid, 1);
            @(negedge clk);
        end
    endtask

    task automatic junk_strobes(input int n);
        for (int k = 0; k < n; k++) begin
            line_rx = k[0]; line_rx_stb = 1'b1;
            @(negedge clk);
            line_rx_stb = 1'b0;
            @(negedge clk);
        end
    endtask

    // Monitor: capture each line burst and compare it with the queued word.
    initial begin
        logic [NB-1:0] got;
        logic [NB-1:0] exp;
        forever begin
            @(negedge clk);
            if (line_tx_en) begin
                got[NB-1] = line_tx;
                for (int k = NB - 2; k >= 0; k--) begin
                    repeat (DIV) @(negedge clk);
                    got[k] = line_tx;
                end
                repeat (DIV - 1) @(negedge clk);
                chk(line_tx_en == 1'b1, "R2 line_tx_en still high in last cycle", line_tx_en, 1);
                @(negedge clk);
                chk(line_tx_en == 1'b0, "R2 line_tx_en low after 10 bit periods", line_tx_en, 0);
                if (tx_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected burst", got, 0);
                end else begin
                    exp = tx_q.pop_front();
                    chk(got == exp, "R1 R5 burst bit order and content", got, exp);
                end
            end
        end
    end

    // Monitor: compare each completed reply with the queued fields.
    initial begin
        logic [NB-1:0] exp;
        forever begin
            @(negedge clk);
            if (rx_valid) begin
                if (rx_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected rx_valid", rx_pcm, 0);
                end else begin
                    exp = rx_q.pop_front();
                    chk({rx_pcm, rx_sig1, rx_sig2} == exp, "R4 R6 received fields",
                        {rx_pcm, rx_sig1, rx_sig2}, exp);
                    chk(frame_missed == 1'b0, "R4 frame_missed cleared", frame_missed, 0);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [VW-1:0] held;
        int cnt;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({line_tx_en, line_tx, rx_pcm, rx_sig1, rx_sig2, rx_valid, frame_missed} == '0,
            "R10 reset outputs", {line_tx_en, line_tx, rx_pcm, rx_sig1, rx_sig2, rx_valid, frame_missed}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Plain frames with several patterns (R1, R2, R4)
        start_frame(8'hA5, 1'b1, 1'b0); wait_burst_end(); send_reply(8'h3C, 1'b0, 1'b1);
        start_frame(8'hFF, 1'b0, 1'b1); wait_burst_end(); send_reply(8'h81, 1'b1, 1'b1);
        start_frame(8'h00, 1'b1, 1'b1); wait_burst_end(); send_reply(8'h7E, 1'b1, 1'b0);

        // R3: strobes while idle and during the burst are ignored
        junk_strobes(4);
        start_frame(8'h5A, 1'b0, 1'b0);
        junk_strobes(6);
        wait_burst_end();
        send_reply(8'hC3, 1'b0, 1'b1);

        // R5, R6: signaling bit 1 in the PCM LSB
        lsb_data_en = 1'b1;
        start_frame(8'h41, 1'b0, 1'b0); wait_burst_end(); send_reply(8'h40, 1'b1, 1'b0);
        start_frame(8'h80, 1'b1, 1'b1); wait_burst_end(); send_reply(8'h81, 1'b0, 1'b1);
        lsb_data_en = 1'b0;

        // R7: no reply before the next frame sync
        start_frame(8'h12, 1'b1, 1'b0); wait_burst_end();
        held = rx_pcm;
        repeat (20) @(negedge clk);
        start_frame(8'h34, 1'b0, 1'b1);
        chk(frame_missed == 1'b1, "R7 frame_missed set", frame_missed, 1);
        chk(rx_pcm == held, "R7 rx_pcm held", rx_pcm, held);
        chk(line_tx_en == 1'b1, "R7 new burst started", line_tx_en, 1);
        wait_burst_end();
        send_reply(8'h56, 1'b0, 1'b0);

        // R8: a frame sync in mid-burst is ignored
        start_frame(8'h9C, 1'b1, 1'b1);
        cnt = 0;
        fork
            begin
                repeat (3 * DIV) @(negedge clk);
                tx_pcm = 8'h00; frame_sync = 1'b1;
                @(negedge clk);
                frame_sync = 1'b0;
            end
            begin
                while (line_tx_en) begin
                    cnt++;
                    @(negedge clk);
                end
            end
        join
        chk(cnt == NB * DIV, "R8 burst length with mid-burst sync", cnt, NB * DIV);
        send_reply(8'hE7, 1'b1, 1'b0);

        // R9: loopback
        loopback_en = 1'b1;
        rx_q.push_back({8'h96, 1'b1, 1'b0});
        start_frame(8'h96, 1'b1, 1'b0);
        cnt = 0;
        while (!rx_valid) begin
            if (line_tx_en) chk(1'b0, "R9 line_tx_en high in loopback", 1, 0);
            line_rx_stb = ~line_rx_stb; line_rx = 1'b1;
            @(negedge clk);
            cnt++;
        end
        line_rx_stb = 1'b0;
        chk(cnt == NB * DIV, "R9 loopback result latency", cnt, NB * DIV);
        loopback_en = 1'b0;

        repeat (30) @(negedge clk);
        chk(tx_q.size() == 0, "R1 all expected bursts seen", tx_q.size(), 0);
        chk(rx_q.size() == 0, "R4 all expected replies seen", rx_q.size(), 0);
        finish_run();
    end
endmodule